// File: doc/BRIEF.md
# Indirect Debug Word Reader

This block is a bus slave that lets software read a bank of internal 32-bit words without mapping each of them into the address space. Software writes a word index together with a start bit into a control register. The block then fetches the selected word over a fixed three-cycle pipeline and latches it into a value register. It also reports, in the control register, whether the fetch is still running and whether the index was out of range.

The bank has NWORDS entries. Entries 0 and 1 are fixed constants that identify the gateware version and build. Entries 2 to NWORDS-1 come from a flat debug input vector, which is assumed to be synchronous to the bus clock. Only the bus side can start a fetch, and the internal words are never written.

Top module: `dbg_reg_reader`

## Requirements
- R1: The control register is at byte offset 0x0 and the value register is at byte offset 0x4. An access to any other offset is acknowledged and reads as zero. A write to any other offset changes nothing.
- R2: `wbAck` rises in the cycle after the bus cycle is accepted (`wbCyc` and `wbStb` high while `wbAck` is low). It stays high for exactly one cycle per access.
- R3: Control bits 15..0 hold the word index, which can be read and written. Control bits 29..16 always read as zero.
- R4: Writing a control word with bit 31 set while idle starts a fetch, and bit 31 then reads 1 (busy). A control write with bit 31 clear only updates the index and starts nothing.
- R5: Busy clears exactly three clock edges after the edge that accepts the start write. The value register takes its new content on that same edge, and not before.
- R6: Index 0 returns VERSION_WORD and index 1 returns BUILD_WORD. An index k from 2 to NWORDS-1 returns `dbgIn[(k-2)*32 +: 32]`.
- R7: An index of NWORDS or more sets the error flag (control bit 30) when the fetch completes. Busy still clears on the same schedule, and the value register keeps its previous content.
- R8: A new start clears the error flag for the whole fetch, and the flag is then set again only if the new index is out of range. A control write that leaves bit 31 clear does not touch the flag.
- R9: While a fetch is busy, every control write is ignored: it neither starts a fetch nor changes the index.
- R10: The value register cannot be written from the bus.
- R11: A synchronous active-high reset clears the index, busy, error and value registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wbCyc | input | 1 | Bus cycle valid |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | ADDR_W | Byte address |
| wbDatW | input | 32 | Write data |
| wbSel | input | 4 | Byte selects (only full-word accesses are expected) |
| wbDatR | output | 32 | Read data, valid while `wbAck` is high |
| wbAck | output | 1 | Access acknowledge |
| dbgIn | input | (NWORDS-2)*32 | Debug words for bank entries 2 and up |

## Verification
The embedded properties assume that every accepted access drives all four byte selects and a word-aligned address. They also assume that the address and write data carry no unknown bits whenever a transfer is accepted. The stimulus meets these assumptions because it uses only whole-word transfers to aligned offsets, each of which raises the strobe for exactly one accepted cycle and drops it as soon as the acknowledge is seen. The debug vector is set once, before reset is released, and is held constant afterwards, so the latency and stability properties never see a source word change in the middle of a fetch.

// File: rtl/dbgrd_pkg.sv
package dbgrd_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAP  = 2'd1,
    ST_SEL  = 2'd2,
    ST_LOAD = 2'd3
  } fetchSt_t;

  typedef struct packed {
    logic capIdx;
    logic selWord;
    logic loadVal;
  } dpStrobe_t;
endpackage

// File: rtl/dbgrd_ctrl.sv
module dbgrd_ctrl
  import dbgrd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic [DATA_W-1:0] wbDatW,
  input  logic [3:0]        wbSel,
  output logic [DATA_W-1:0] wbDatR,
  output logic              wbAck,
  input  logic [DATA_W-1:0] valWord,
  input  logic              rangeOk,
  output logic [IDX_W-1:0]  idxField,
  output dpStrobe_t         strb
);
  localparam int OFF_W = ADDR_W - 2;
  localparam int RSV_W = DATA_W - IDX_W - 2;

  fetchSt_t          stQ;
  logic              ackQ;
  logic              errQ;
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] datRQ;
  logic              accept;
  logic              isCtrl;
  logic              isVal;
  logic              busy;
  logic              ctrlWr;
  logic [DATA_W-1:0] ctrlRd;
  logic [OFF_W-1:0]  wordOff;

  assign accept  = wbCyc && wbStb && !ackQ;
  assign wordOff = wbAdr[ADDR_W-1:2];
  assign isCtrl  = (wordOff == OFF_W'(0));
  assign isVal   = (wordOff == OFF_W'(1));
  assign busy    = (stQ != ST_IDLE);
  assign ctrlWr  = accept && wbWe && isCtrl && !busy;
  assign ctrlRd  = {busy, errQ, {RSV_W{1'b0}}, idxQ};

  always_ff @(posedge clk) begin
    if (rst) begin
      ackQ  <= 1'b0;
      datRQ <= '0;
      errQ  <= 1'b0;
      idxQ  <= '0;
      stQ   <= ST_IDLE;
    end else begin
      ackQ <= accept;
      if (accept && !wbWe) begin
        if (isCtrl)     datRQ <= ctrlRd;
        else if (isVal) datRQ <= valWord;
        else            datRQ <= '0;
      end
      unique case (stQ)
        ST_IDLE: begin
          if (ctrlWr) begin
            idxQ <= wbDatW[IDX_W-1:0];
            if (wbDatW[DATA_W-1]) begin
              errQ <= 1'b0;
              stQ  <= ST_CAP;
            end
          end
        end
        ST_CAP:  stQ <= ST_SEL;
        ST_SEL:  stQ <= ST_LOAD;
        ST_LOAD: begin
          if (!rangeOk) errQ <= 1'b1;
          stQ <= ST_IDLE;
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capIdx  = (stQ == ST_CAP);
    strb.selWord = (stQ == ST_SEL);
    strb.loadVal = (stQ == ST_LOAD) && rangeOk;
  end

  assign wbDatR   = datRQ;
  assign wbAck    = ackQ;
  assign idxField = idxQ;

  // input assumptions checked at every accepted transfer
  AST_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
    (accept && wbWe) |-> (wbSel == 4'hF));                          // R1
  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    accept |-> (!$isunknown(wbAdr) && wbAdr[1:0] == 2'b00));        // R1
  AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (rst)
    (accept && wbWe) |-> !$isunknown(wbDatW));                      // R3

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck);                                              // R2
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbAck) |=> wbAck);                          // R2
  AST_FETCH_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ##2 busy ##1 !busy);                            // R5
  AST_ERR_CLR_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !errQ);                                         // R8
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(idxQ));                                        // R9
endmodule

// File: rtl/dbgrd_dpath.sv
module dbgrd_dpath
  import dbgrd_pkg::*;
#(
  parameter int          NWORDS      = 8,
  parameter logic [31:0] VERSION_WORD = 32'h0003_0102,
  parameter logic [31:0] BUILD_WORD   = 32'h2406_1157
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dpStrobe_t                  strb,
  input  logic [IDX_W-1:0]           idxField,
  input  logic [(NWORDS-2)*DATA_W-1:0] dbgIn,
  output logic [DATA_W-1:0]          valWord,
  output logic                       rangeOk
);
  localparam int SEL_W  = (NWORDS > 2) ? $clog2(NWORDS) : 1;
  localparam int BANK_N = 1 << SEL_W;

  logic [DATA_W-1:0] bank [BANK_N];
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] selQ;
  logic              okQ;
  logic [DATA_W-1:0] valQ;
  logic              inRange;

  for (genvar k = 0; k < BANK_N; k++) begin : g_bank
    if (k == 0) begin : g_ver
      assign bank[k] = VERSION_WORD;
    end else if (k == 1) begin : g_bld
      assign bank[k] = BUILD_WORD;
    end else if (k < NWORDS) begin : g_dbg
      assign bank[k] = dbgIn[(k-2)*DATA_W +: DATA_W];
    end else begin : g_pad
      assign bank[k] = '0;
    end
  end

  assign inRange = (32'(idxQ) < NWORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ <= '0;
      selQ <= '0;
      okQ  <= 1'b0;
      valQ <= '0;
    end else begin
      if (strb.capIdx)  idxQ <= idxField;
      if (strb.selWord) begin
        okQ  <= inRange;
        selQ <= inRange ? bank[idxQ[SEL_W-1:0]] : '0;
      end
      if (strb.loadVal) valQ <= selQ;
    end
  end

  assign valWord = valQ;
  assign rangeOk = okQ;

  AST_VAL_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    !okQ |=> $stable(valQ));                                        // R7
  AST_VAL_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !strb.loadVal |=> $stable(valQ));                               // R10
endmodule

// File: rtl/dbg_reg_reader.sv
module dbg_reg_reader
  import dbgrd_pkg::*;
#(
  parameter int          ADDR_W       = 4,
  parameter int          NWORDS       = 8,
  parameter logic [31:0] VERSION_WORD = 32'h0003_0102,
  parameter logic [31:0] BUILD_WORD   = 32'h2406_1157
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wbCyc,
  input  logic                       wbStb,
  input  logic                       wbWe,
  input  logic [ADDR_W-1:0]          wbAdr,
  input  logic [31:0]                wbDatW,
  input  logic [3:0]                 wbSel,
  output logic [31:0]                wbDatR,
  output logic                       wbAck,
  input  logic [(NWORDS-2)*32-1:0]   dbgIn
);
  dpStrobe_t         strb;
  logic [IDX_W-1:0]  idxField;
  logic [DATA_W-1:0] valWord;
  logic              rangeOk;

  dbgrd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr),
    .wbDatW(wbDatW), .wbSel(wbSel), .wbDatR(wbDatR), .wbAck(wbAck),
    .valWord(valWord), .rangeOk(rangeOk), .idxField(idxField), .strb(strb)
  );

  dbgrd_dpath #(
    .NWORDS(NWORDS), .VERSION_WORD(VERSION_WORD), .BUILD_WORD(BUILD_WORD)
  ) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .idxField(idxField),
    .dbgIn(dbgIn), .valWord(valWord), .rangeOk(rangeOk)
  );
endmodule

// File: tb/tb_dbg_reg_reader.sv
module tb_dbg_reg_reader;
  localparam int          NW  = 8;
  localparam logic [31:0] VER = 32'h0003_0102;
  localparam logic [31:0] BLD = 32'h2406_1157;
  localparam logic [3:0]  A_CTRL = 4'h0;
  localparam logic [3:0]  A_VAL  = 4'h4;

  typedef struct packed { logic [15:0] idx; logic err; } vec_t;
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{16'd0, 1'b0}, '{16'd1, 1'b0}, '{16'd2, 1'b0}, '{16'd5, 1'b0},
    '{16'd7, 1'b0}, '{16'd8, 1'b1}, '{16'd3, 1'b0}, '{16'hFFFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [3:0]  wbAdr = '0;
  logic [31:0] wbDatW = '0;
  logic [3:0]  wbSel = 4'hF;
  logic [31:0] wbDatR;
  logic        wbAck;
  logic [(NW-2)*32-1:0] dbgIn;

  int total = 0;
  int bad   = 0;
  logic [31:0] rd;
  logic [31:0] expVal;

  always #10 clk = ~clk;

  dbg_reg_reader #(.ADDR_W(4), .NWORDS(NW), .VERSION_WORD(VER), .BUILD_WORD(BLD)) dut (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatW(wbDatW), .wbSel(wbSel), .wbDatR(wbDatR),
    .wbAck(wbAck), .dbgIn(dbgIn)
  );

  function automatic logic [31:0] wordOf(input logic [15:0] i);
    if (i == 16'd0) return VER;
    if (i == 16'd1) return BLD;
    return 32'hC0DE_0000 + 32'(i) * 32'd17;
  endfunction

  function automatic logic [31:0] ctrlOf(input logic b, input logic e, input logic [15:0] i);
    return {b, e, 14'b0, i};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: accept edge, then an idle edge; acknowledge timing checked (R2)
  task automatic bus(input logic we, input logic [3:0] adr, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = we; wbAdr = adr; wbDatW = d;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ack high", 32'(wbAck), 32'd1);
    q = wbDatR;
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ack single", 32'(wbAck), 32'd0);
  endtask

  task automatic wr(input logic [3:0] adr, input logic [31:0] d);
    logic [31:0] junk;
    bus(1'b1, adr, d, junk);
  endtask

  task automatic rdReg(input logic [3:0] adr, output logic [31:0] q);
    bus(1'b0, adr, '0, q);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 2; k < NW; k++) dbgIn[(k-2)*32 +: 32] = wordOf(16'(k));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state
    rdReg(A_CTRL, rd); chk("R11 ctrl after reset", rd, 32'h0);
    rdReg(A_VAL, rd);  chk("R11 value after reset", rd, 32'h0);
    expVal = 32'h0;

    // vector table: start, busy at E2, done at E4, value
    for (int v = 0; v < NVEC; v++) begin
      wr(A_CTRL, {1'b1, 15'b0, VECS[v].idx});
      rdReg(A_CTRL, rd); chk("R4/R8 busy, error cleared", rd, ctrlOf(1'b1, 1'b0, VECS[v].idx));
      rdReg(A_CTRL, rd); chk("R5/R7 done status", rd, ctrlOf(1'b0, VECS[v].err, VECS[v].idx));
      if (!VECS[v].err) expVal = wordOf(VECS[v].idx);
      rdReg(A_VAL, rd);  chk(VECS[v].err ? "R7 value kept" : "R6 fetched word", rd, expVal);
    end

    // R8: error stays after index-only write; R4: no fetch started
    wr(A_CTRL, 32'h0000_0004);
    rdReg(A_CTRL, rd); chk("R4/R8 index-only write", rd, ctrlOf(1'b0, 1'b1, 16'd4));
    rdReg(A_VAL, rd);  chk("R4 no fetch on bit31=0", rd, expVal);

    // R3 reserved bits read zero
    wr(A_CTRL, 32'h3FFF_0002);
    rdReg(A_CTRL, rd); chk("R3 reserved bits zero", rd, ctrlOf(1'b0, 1'b1, 16'd2));

    // R5: value not updated before busy clears, updated when it clears
    wr(A_CTRL, 32'h8000_0006);
    rdReg(A_VAL, rd); chk("R5 value old during fetch", rd, expVal);
    rdReg(A_VAL, rd); chk("R5 value new at completion", rd, wordOf(16'd6));
    expVal = wordOf(16'd6);

    // R9 writes during fetch ignored
    wr(A_CTRL, 32'h8000_0003);
    wr(A_CTRL, 32'h8000_0009);
    rdReg(A_CTRL, rd); chk("R9 index frozen, no restart", rd, ctrlOf(1'b0, 1'b0, 16'd3));
    rdReg(A_VAL, rd);  chk("R9 first fetch wins", rd, wordOf(16'd3));
    expVal = wordOf(16'd3);

    // R10 value register write ignored
    wr(A_VAL, 32'hDEAD_BEEF);
    rdReg(A_VAL, rd); chk("R10 value read-only", rd, expVal);

    // R1 other offsets: acked, read zero, writes no effect
    wr(4'h8, 32'h8000_0001);
    rdReg(4'h8, rd);   chk("R1 unmapped reads zero", rd, 32'h0);
    rdReg(4'hC, rd);   chk("R1 unmapped reads zero", rd, 32'h0);
    rdReg(A_CTRL, rd); chk("R1 unmapped write no effect", rd, ctrlOf(1'b0, 1'b0, 16'd3));

    // R11 reset in the middle of a fetch
    wr(A_CTRL, 32'h8000_0005);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rdReg(A_CTRL, rd); chk("R11 mid-fetch reset ctrl", rd, 32'h0);
    repeat (4) @(posedge clk);
    rdReg(A_VAL, rd);  chk("R11 mid-fetch reset value", rd, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule